// File: doc/BRIEF.md
# Three-Phase Sine DAC Sequencer

This block drives a quad 8-bit digital-to-analog converter through one shared write port: an 8-bit data bus, a 2-bit channel address and an active-low write strobe. Three of the channels carry sine waves that stay 120 degrees apart. One phase register indexes a 256-entry sine table that is built as constant logic when the design is elaborated. Each step request sends a group of three samples to channels A, B and C, one after the other. The phase then advances by one table entry, which is 360/256 or about 1.4 degrees.

The fourth channel, D, receives an 8-bit amplitude code. In the target system this channel sets the shared reference voltage, so the code scales all three sines together. The code is written only at a boundary between groups, so the three samples of one group always share one amplitude. Step requests that arrive while a group is in progress are held until the block can serve them.

Top module: `tri_phase_dac_seq`

## Requirements
- R1: During and after reset, and before any request, the strobe `dac_wr_n_o` is high, `dac_addr_o` is 0 and `dac_data_o` is 0. The phase index starts at 0, so the first group writes table entry 0 (value 128) to channel A.
- R2: Every write lasts three clocks. In the first clock the address and data are driven with the strobe high. In the second clock the strobe is low, for exactly one clock. In the third clock the strobe is high again. Address and data hold the same value across all three clocks.
- R3: The address encoding is 0 for channel A, 1 for channel B, 2 for channel C and 3 for channel D.
- R4: For phase p, a group writes channel A with T[p], then channel B with T[(p+85) mod 256], then channel C with T[(p+171) mod 256]. The three writes follow each other with no gap and with no other write between them.
- R5: Table entry T[k] equals round(128 + 127·sin(2πk/256)), which lies in the range 1 to 255.
- R6: The phase index advances by one after each group and wraps from 255 to 0. Group number 257 therefore repeats the samples of group 1.
- R7: A step request that arrives while a write is in progress is held pending and served later. Several requests that arrive while one is already pending merge into a single group.
- R8: A pulse on `amp_load_i` captures `amp_i`. The captured code is written to channel D only when no group is in progress, never between the A and C writes. A load that arrives during a group gives a D write right after that group's C write.
- R9: At a boundary where both an amplitude write and a group are pending, the D write goes first. The exception is a boundary that directly follows a D write: there the group goes first, so repeated amplitude loads cannot hold back steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| step_i | input | 1 | Request to write one group and advance the phase |
| amp_i | input | 8 | Amplitude code for channel D |
| amp_load_i | input | 1 | Captures `amp_i` and requests a D write |
| dac_addr_o | output | 2 | Channel address (0=A, 1=B, 2=C, 3=D) |
| dac_data_o | output | 8 | Data word to the converter |
| dac_wr_n_o | output | 1 | Active-low write strobe |

## Verification
Assertions check the bus timing on every cycle: the strobe is low for a single clock, and address and data are stable from setup through hold. They also check the order of writes: B follows A, C follows B, and a D write or a new A write comes only after C or after D. Three things can only be shown by the bench's scenarios: the sample values against an independently computed sine, the phase wrap after 256 groups, and how pending steps merge and how the two request kinds are ordered at a boundary.

// File: rtl/tri_phase_dac_seq.sv
module tri_phase_dac_seq #(
  parameter int DW = 8,
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step_i,
  input  logic [DW-1:0] amp_i,
  input  logic          amp_load_i,
  output logic [1:0]    dac_addr_o,
  output logic [DW-1:0] dac_data_o,
  output logic          dac_wr_n_o
);

  localparam int N = 1 << PW;
  localparam logic [PW-1:0] OFS_B = PW'((N + 1) / 3);
  localparam logic [PW-1:0] OFS_C = PW'((2 * N + 1) / 3);
  localparam logic [1:0] CH_A = 2'd0, CH_B = 2'd1, CH_C = 2'd2, CH_D = 2'd3;

  function automatic logic [DW-1:0] sine_code(input int k);
    real x, t, s, mid;
    mid = real'(1 << (DW - 1));
    x = 6.283185307179586 * real'(k) / real'(N);
    if (x > 3.141592653589793) x = x - 6.283185307179586;
    t = x;
    s = x;
    for (int n = 1; n <= 10; n++) begin
      t = -t * x * x / real'((2 * n) * (2 * n + 1));
      s = s + t;
    end
    return DW'($rtoi(mid + (mid - 1.0) * s + 0.5));
  endfunction

  logic [DW-1:0] rom [N];
  for (genvar g = 0; g < N; g++) begin : g_rom
    localparam logic [DW-1:0] V = sine_code(g);
    assign rom[g] = V;
  end

  logic [PW-1:0] ph;
  logic [1:0]    cnt, chan;
  logic          busy, step_pend, amp_pend;
  logic [DW-1:0] amp_q;

  wire at_end  = busy && cnt == 2'd2;
  wire bound   = !busy || (at_end && (chan == CH_C || chan == CH_D));
  wire last_d  = busy && chan == CH_D;
  wire go_d    = bound && amp_pend && (!last_d || !step_pend);
  wire go_a    = bound && !go_d && step_pend;
  wire go_next = at_end && (chan == CH_A || chan == CH_B);
  wire load    = go_d || go_a || go_next;
  wire ph_inc  = at_end && chan == CH_C;

  wire [PW-1:0] ph_nx = ph_inc ? ph + 1'b1 : ph;
  wire [1:0]    nchan = go_d ? CH_D : go_a ? CH_A : chan + 2'd1;

  logic [DW-1:0] dsel;
  always_comb begin
    case (nchan)
      CH_A:    dsel = rom[ph_nx];
      CH_B:    dsel = rom[ph_nx + OFS_B];
      CH_C:    dsel = rom[ph_nx + OFS_C];
      default: dsel = amp_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph <= '0; cnt <= '0; chan <= '0; busy <= 1'b0;
      step_pend <= 1'b0; amp_pend <= 1'b0; amp_q <= '0;
      dac_addr_o <= '0; dac_data_o <= '0; dac_wr_n_o <= 1'b1;
    end else begin
      step_pend <= step_i | (step_pend & ~go_a);
      amp_pend  <= amp_load_i | (amp_pend & ~go_d);
      if (amp_load_i) amp_q <= amp_i;
      if (ph_inc) ph <= ph + 1'b1;
      if (load) begin
        busy <= 1'b1;
        chan <= nchan;
        cnt  <= 2'd0;
        dac_addr_o <= nchan;
        dac_data_o <= dsel;
        dac_wr_n_o <= 1'b1;
      end else if (busy) begin
        if (cnt == 2'd0) begin
          cnt <= 2'd1; dac_wr_n_o <= 1'b0;
        end else if (cnt == 2'd1) begin
          cnt <= 2'd2; dac_wr_n_o <= 1'b1;
        end else begin
          busy <= 1'b0;
        end
      end
    end
  end

  logic [1:0] seen_q;
  logic       seen_v;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen_q <= '0; seen_v <= 1'b0;
    end else if (!dac_wr_n_o) begin
      seen_q <= dac_addr_o; seen_v <= 1'b1;
    end
  end

  p_strobe_one_clk_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !dac_wr_n_o |=> dac_wr_n_o);
  p_setup_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dac_wr_n_o) |-> $stable(dac_addr_o) && $stable(dac_data_o));
  p_hold_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dac_wr_n_o) |-> $stable(dac_addr_o) && $stable(dac_data_o));
  p_b_after_a_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dac_wr_n_o) && dac_addr_o == CH_B) |-> seen_v && seen_q == CH_A);
  p_c_after_b_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dac_wr_n_o) && dac_addr_o == CH_C) |-> seen_v && seen_q == CH_B);
  p_a_at_boundary_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dac_wr_n_o) && dac_addr_o == CH_A) |-> !seen_v || seen_q == CH_C || seen_q == CH_D);
  p_amp_between_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dac_wr_n_o) && dac_addr_o == CH_D) |-> !seen_v || seen_q == CH_C || seen_q == CH_D);

endmodule

// File: tb/tri_phase_dac_seq_test.sv
module tri_phase_dac_seq_test;
  logic clk = 1'b0, rst_n = 1'b0, step_i = 1'b0, amp_load_i = 1'b0;
  logic [7:0] amp_i = '0;
  logic [1:0] dac_addr_o;
  logic [7:0] dac_data_o;
  logic       dac_wr_n_o;

  tri_phase_dac_seq uut (.clk(clk), .rst_n(rst_n), .step_i(step_i), .amp_i(amp_i),
    .amp_load_i(amp_load_i), .dac_addr_o(dac_addr_o), .dac_data_o(dac_data_o),
    .dac_wr_n_o(dac_wr_n_o));

  always #5 clk = ~clk;

  int nchk = 0, nfail = 0, nw = 0, mph = 0;
  int wa [0:4095];
  int wd [0:4095];
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ref_sine(input int k);
    return $rtoi(128.0 + 127.0 * $sin(2.0 * 3.14159265358979 * real'(k) / 256.0) + 0.5);
  endfunction

  logic       prev_wr = 1'b1, hold_pend = 1'b0;
  logic [1:0] prev_a = '0, ha = '0;
  logic [7:0] prev_d = '0, hd = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (hold_pend) begin
        chk(dac_wr_n_o && dac_addr_o == ha && dac_data_o == hd, "R2 hold", int'(dac_data_o), int'(hd));
        hold_pend = 1'b0;
      end
      if (!dac_wr_n_o) begin
        chk(prev_wr && prev_a == dac_addr_o && prev_d == dac_data_o, "R2 setup", int'(prev_d), int'(dac_data_o));
        if (nw < 4096) begin
          wa[nw] = int'(dac_addr_o);
          wd[nw] = int'(dac_data_o);
        end
        nw++;
        hold_pend = 1'b1; ha = dac_addr_o; hd = dac_data_o;
      end
    end
    prev_wr = dac_wr_n_o; prev_a = dac_addr_o; prev_d = dac_data_o;
  end

  task automatic expect_triad(input int b);
    chk(wa[b] == 0, "R3 addr A", wa[b], 0);
    chk(wa[b+1] == 1, "R3 addr B", wa[b+1], 1);
    chk(wa[b+2] == 2, "R3 addr C", wa[b+2], 2);
    chk(wd[b] == ref_sine(mph), "R5 data A", wd[b], ref_sine(mph));
    chk(wd[b+1] == ref_sine((mph + 85) % 256), "R4 data B", wd[b+1], ref_sine((mph + 85) % 256));
    chk(wd[b+2] == ref_sine((mph + 171) % 256), "R4 data C", wd[b+2], ref_sine((mph + 171) % 256));
    mph = (mph + 1) % 256;
  endtask

  task automatic expect_amp(input int b, input int code);
    chk(wa[b] == 3, "R8 addr D", wa[b], 3);
    chk(wd[b] == code, "R8 amp code", wd[b], code);
  endtask

  task automatic pulse_step;
    @(negedge clk) step_i = 1'b1;
    @(negedge clk) step_i = 1'b0;
  endtask

  task automatic load_amp(input int code);
    @(negedge clk) begin amp_i = 8'(code); amp_load_i = 1'b1; end
    @(negedge clk) amp_load_i = 1'b0;
  endtask

  task automatic settle;
    repeat (40) @(negedge clk);
  endtask

  initial begin
    int b;
    repeat (3) @(negedge clk);
    chk(dac_wr_n_o == 1'b1, "R1 strobe in reset", int'(dac_wr_n_o), 1);
    chk(dac_addr_o == 2'd0 && dac_data_o == 8'd0, "R1 bus in reset", int'(dac_data_o), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(dac_wr_n_o == 1'b1 && nw == 0, "R1 idle after reset", nw, 0);

    b = nw; pulse_step; settle;
    chk(nw == b + 3, "R4 one group", nw - b, 3);
    chk(wd[b] == 128, "R1 first sample", wd[b], 128);
    expect_triad(b);

    b = nw; pulse_step; repeat (2) @(negedge clk); pulse_step; pulse_step; settle;
    chk(nw == b + 6, "R7 pending merge", nw - b, 6);
    expect_triad(b); expect_triad(b + 3);

    b = nw; load_amp(8'h5A); settle;
    chk(nw == b + 1, "R8 single D write", nw - b, 1);
    expect_amp(b, 8'h5A);

    b = nw; pulse_step; repeat (3) @(negedge clk); load_amp(8'hC3); settle;
    chk(nw == b + 4, "R8 group then D", nw - b, 4);
    expect_triad(b); expect_amp(b + 3, 8'hC3);

    b = nw;
    @(negedge clk) begin step_i = 1'b1; amp_i = 8'h11; amp_load_i = 1'b1; end
    @(negedge clk) begin step_i = 1'b0; amp_load_i = 1'b0; end
    settle;
    chk(nw == b + 4, "R9 both pending", nw - b, 4);
    expect_amp(b, 8'h11); expect_triad(b + 1);

    b = nw; load_amp(8'h22);
    @(negedge clk) begin step_i = 1'b1; amp_i = 8'h33; amp_load_i = 1'b1; end
    @(negedge clk) begin step_i = 1'b0; amp_load_i = 1'b0; end
    settle;
    chk(nw == b + 5, "R9 after D", nw - b, 5);
    expect_amp(b, 8'h22); expect_triad(b + 1); expect_amp(b + 4, 8'h33);

    for (int i = 0; i < 300 && nw < 4000; i++) begin
      b = nw; pulse_step; repeat (14) @(negedge clk);
      chk(nw == b + 3, "R6 sweep group", nw - b, 3);
      if (mph == 0) chk(wd[b] == 128, "R6 wrap to zero", wd[b], 128);
      expect_triad(b);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end
endmodule